// File: doc/BRIEF.md
# Byte-wide SPI master/slave serial port

This block is an eight-bit synchronous serial port that can act either as the clock-driving master or as a clocked slave on an SPI link. A four-bit role selector chooses master operation with one of three fixed system-clock dividers or with an external timer tick, or slave operation with the select input either honoured or ignored. One shared data buffer serves both directions. A host write to it loads the shift register and, in master role, starts a transfer. A received byte is placed back into the same buffer and raises a buffer-full bit. The host then reads the buffer, which clears that bit.

Two sticky error flags report misuse. The first is a write collision, where the host writes while a byte is still shifting. The second is a slave receive overflow, where a byte completes while the previous one is still unread. Each flag holds until its own clear strobe. Bits travel MSB first. The output bit changes on the SCK edge that leaves the idle level, and the input bit is sampled on the edge that returns to it. When the enable is low the port drives no pin and ignores its pin inputs.

Top module: `spi_port`

## Requirements
- R1: After reset wcol_o, ovf_o, buf_full_o and busy_o are 0, buf_rdata_o is 0x00, and sck_oe_o and sdo_oe_o are 0.
- R2: With en_i low the port drives no pin (sck_oe_o = sdo_oe_o = 0), activity on sck_i/sdi_i completes no byte (buf_full_o stays 0), and busy_o is 0 from the cycle after en_i is low.
- R3: In a master mode (mode_i = 4'b00xx), a buffer write while idle shifts that byte out MSB first on sdo_o; the 8 bits taken from sdi_i then appear in buf_rdata_o with buf_full_o set as busy_o falls.
- R4: Master SCK period is 4, 16 or 64 clock cycles for mode_i = 0000, 0001, 0010; with mode_i = 0011 SCK toggles once per tmr_tick_i pulse (period of two ticks).
- R5: cpol_i sets the SCK idle level (1 = high, 0 = low); in master role sck_o rests at that level while no transfer is active.
- R6: A buffer write while busy_o is 1 sets wcol_o, leaves the byte in flight and the buffer unchanged, and wcol_o stays 1 until clr_wcol_i.
- R7: In slave role, a byte completing while buf_full_o is 1 sets ovf_o, the buffer keeps the older byte, and ovf_o stays 1 until clr_ovf_i.
- R8: In a master mode ovf_o is never set, even when received bytes are left unread; each new byte replaces the buffer.
- R9: With mode_i = 0100 the slave is selected only while ss_ni is low; while ss_ni is high sdo_oe_o is 0, and raising ss_ni mid-byte drops the partial byte and restarts the bit count, so the next full byte is received intact.
- R10: With mode_i = 0101 the slave transfers regardless of ss_ni and drives sdo_o continuously.
- R11: In slave role the byte written to the buffer before a transfer appears on sdo_o MSB first, one bit per SCK leading edge.
- R12: A buf_rd_i pulse clears buf_full_o when no byte is completing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low returns the pins to general I/O |
| mode_i | input | 4 | Role and clock-source selector |
| cpol_i | input | 1 | SCK idle level |
| buf_wr_i | input | 1 | Host write strobe for the data buffer |
| buf_wdata_i | input | 8 | Host write data |
| buf_rd_i | input | 1 | Host read strobe; clears buffer-full |
| buf_rdata_o | output | 8 | Data buffer contents |
| clr_wcol_i | input | 1 | Clears the write-collision flag |
| clr_ovf_i | input | 1 | Clears the overflow flag |
| tmr_tick_i | input | 1 | External timer tick for mode 0011 |
| wcol_o | output | 1 | Sticky write-collision flag |
| ovf_o | output | 1 | Sticky receive-overflow flag |
| buf_full_o | output | 1 | Buffer holds an unread received byte |
| busy_o | output | 1 | A byte is shifting or being stored |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated in master role |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| ss_ni | input | 1 | Slave select, active low |

## Verification
Master transfers use random bytes looped from sdo_o back into sdi_i, across all three divider settings and both clock polarities. A byte that comes back intact shows MSB-first order and correct edge alignment, and a measured SCK period tells each divider and the timer source apart. Slave transfers drive random bytes on sdi_i while the bench reads sdo_o, so the receive and transmit paths are checked independently. Directed cases cover back-to-back unread slave bytes (overflow against silent replacement in master role), a write issued mid-transfer, a select raised after three bits, and pin activity with the port disabled.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [3:0] MODE_M_DIV4   = 4'b0000;
  localparam logic [3:0] MODE_M_DIV16  = 4'b0001;
  localparam logic [3:0] MODE_M_DIV64  = 4'b0010;
  localparam logic [3:0] MODE_M_TMR    = 4'b0011;
  localparam logic [3:0] MODE_S_SEL    = 4'b0100;
  localparam logic [3:0] MODE_S_NOSEL  = 4'b0101;

  localparam int unsigned SCK_DIV_FAST = 4;
  localparam int unsigned SCK_DIV_MID  = 16;
  localparam int unsigned SCK_DIV_SLOW = 64;

  function automatic logic is_master(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic is_slave(input logic [3:0] m);
    return (m == MODE_S_SEL) || (m == MODE_S_NOSEL);
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       tmr_tick_i,
  output logic       half_tick_o
);
  localparam int unsigned HALF_MAX = SCK_DIV_SLOW / 2;
  localparam int unsigned CW = $clog2(HALF_MAX);
  localparam logic [CW-1:0] LIM_FAST = CW'(SCK_DIV_FAST / 2 - 1);
  localparam logic [CW-1:0] LIM_MID  = CW'(SCK_DIV_MID / 2 - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(SCK_DIV_SLOW / 2 - 1);

  logic [CW-1:0] cnt_q, lim;
  logic          wrap;

  always_comb begin
    case (sel_i)
      2'd0:    lim = LIM_FAST;
      2'd1:    lim = LIM_MID;
      default: lim = LIM_SLOW;
    endcase
  end

  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || sel_i == 2'd3 || wrap) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign half_tick_o = run_i && ((sel_i == 2'd3) ? tmr_tick_i : wrap);
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         start_on_load_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         sdi_i,
  output logic         active_o,
  output logic         done_o,
  output logic         sdo_o,
  output logic [W-1:0] rx_o
);
  localparam int unsigned CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  logic [W-1:0]    sr_q;
  logic [CNTW-1:0] cnt_q;
  logic            active_q, done_q, sdo_q;
  logic            last_trail;

  assign last_trail = trail_i && active_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_trail;
      if (load_i && !active_q) begin
        sr_q  <= load_data_i;
        cnt_q <= '0;
        if (start_on_load_i) active_q <= 1'b1;
      end
      if (lead_i) begin
        active_q <= 1'b1;
        sdo_q    <= sr_q[W-1];
      end
      if (trail_i && active_q) begin
        sr_q <= {sr_q[W-2:0], sdi_i};
        if (last_trail) begin
          cnt_q    <= '0;
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign sdo_o    = sdo_q;
  assign rx_o     = sr_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        mode_i,
  input  logic              cpol_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic              clr_wcol_i,
  input  logic              clr_ovf_i,
  input  logic              tmr_tick_i,
  output logic              wcol_o,
  output logic              ovf_o,
  output logic              buf_full_o,
  output logic              busy_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ss_ni
);
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PIN_W = 3;

  logic [PIN_W-1:0] pin_s;
  logic sck_s, sdi_s, ss_s, sck_prev_q;
  logic role_m, role_s, sel_used, sel_ok;
  logic core_active, core_done, core_sdo, core_clr, core_load;
  logic [DATA_W-1:0] core_rx;
  logic half_tick, sck_lvl_q, m_run;
  logic m_lead, m_trail, s_edge, s_lead, s_trail;
  logic busy, wr_hit;
  logic [DATA_W-1:0] buf_q;
  logic full_q, wcol_q, ovf_q;

  spi_port_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sdi_i, sck_i}),
    .q_o   (pin_s)
  );

  assign sck_s = pin_s[0];
  assign sdi_s = pin_s[1];
  assign ss_s  = pin_s[2];

  assign role_m   = en_i && is_master(mode_i);
  assign role_s   = en_i && is_slave(mode_i);
  assign sel_used = (mode_i == MODE_S_SEL);
  assign sel_ok   = role_s && (!sel_used || !ss_s);

  // master clock
  assign m_run = role_m && core_active;

  spi_port_clkgen i_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (m_run),
    .sel_i      (mode_i[1:0]),
    .tmr_tick_i (tmr_tick_i),
    .half_tick_o(half_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_lvl_q <= 1'b0;
    else if (!m_run) sck_lvl_q <= cpol_i;
    else if (half_tick) sck_lvl_q <= ~sck_lvl_q;
  end

  assign m_lead  = m_run && half_tick && (sck_lvl_q == cpol_i);
  assign m_trail = m_run && half_tick && (sck_lvl_q != cpol_i);

  // slave edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else sck_prev_q <= sck_s;
  end

  assign s_edge  = sel_ok && (sck_s != sck_prev_q);
  assign s_lead  = s_edge && (sck_s != cpol_i);
  assign s_trail = s_edge && (sck_s == cpol_i);

  // shift core
  assign busy      = core_active || core_done;
  assign wr_hit    = buf_wr_i && (role_m || role_s);
  assign core_load = wr_hit && !busy;
  assign core_clr  = !(role_m || role_s) || (role_s && sel_used && ss_s);

  spi_port_shift #(.W(DATA_W)) i_shift (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clr_i          (core_clr),
    .load_i         (core_load),
    .load_data_i    (buf_wdata_i),
    .start_on_load_i(role_m),
    .lead_i         (m_lead || s_lead),
    .trail_i        (m_trail || s_trail),
    .sdi_i          (role_m ? sdi_i : sdi_s),
    .active_o       (core_active),
    .done_o         (core_done),
    .sdo_o          (core_sdo),
    .rx_o           (core_rx)
  );

  // buffer and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (core_load) buf_q <= buf_wdata_i;
      if (core_done) begin
        if (role_s && full_q) begin
          ovf_q <= 1'b1;
        end else begin
          buf_q  <= core_rx;
          full_q <= 1'b1;
        end
      end else begin
        if (buf_rd_i) full_q <= 1'b0;
        if (clr_ovf_i) ovf_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcol_q <= 1'b0;
    else if (wr_hit && busy) wcol_q <= 1'b1;
    else if (clr_wcol_i) wcol_q <= 1'b0;
  end

  assign buf_rdata_o = buf_q;
  assign buf_full_o  = full_q;
  assign wcol_o      = wcol_q;
  assign ovf_o       = ovf_q;
  assign busy_o      = busy;
  assign sck_o       = sck_lvl_q;
  assign sck_oe_o    = role_m;
  assign sdo_o       = core_sdo;
  assign sdo_oe_o    = role_m || sel_ok;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [3:0] mode_i,
  input logic       buf_rd_i,
  input logic       clr_wcol_i,
  input logic       clr_ovf_i,
  input logic       wcol_o,
  input logic       ovf_o,
  input logic       buf_full_o,
  input logic       busy_o
);
  p_disable_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);

  p_done_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(mode_i[3:2]) == 2'b00 && !$past(buf_rd_i) && $fell(busy_o))
      |-> buf_full_o);

  p_wcol_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !clr_wcol_i) |=> wcol_o);

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[3:2] == 2'b00 && !ovf_o) |=> !ovf_o);

  p_rd_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_i && !busy_o) |=> !buf_full_o);
endmodule

bind spi_port spi_port_chk i_chk (.*);

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [3:0] mode_i = 4'b0000;
  logic cpol_i = 1'b0;
  logic buf_wr_i = 1'b0;
  logic [7:0] buf_wdata_i = '0;
  logic buf_rd_i = 1'b0;
  logic [7:0] buf_rdata_o;
  logic clr_wcol_i = 1'b0;
  logic clr_ovf_i = 1'b0;
  logic tmr_tick_i = 1'b0;
  logic wcol_o, ovf_o, buf_full_o, busy_o;
  logic sck_i = 1'b0;
  logic sck_o, sck_oe_o;
  logic sdi_i;
  logic sdo_o, sdo_oe_o;
  logic ss_ni = 1'b1;
  logic loop_en = 1'b1;
  logic sdi_drv = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   cyc_cnt = 0;
  int   tick_div = 0;

  localparam int HALF = 8;

  always #2 clk_i = ~clk_i;

  assign sdi_i = loop_en ? sdo_o : sdi_drv;

  spi_port i_spi_port (.*);

  always @(negedge clk_i) begin
    tick_div <= (tick_div == 4) ? 0 : tick_div + 1;
    tmr_tick_i <= (tick_div == 4);
  end

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_period(input logic [3:0] m);
    case (m)
      4'b0000: return 4;
      4'b0001: return 16;
      4'b0010: return 64;
      default: return 10;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic host_wr(input logic [7:0] d);
    buf_wr_i = 1'b1; buf_wdata_i = d;
    cyc(1);
    buf_wr_i = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] d);
    d = buf_rdata_o;
    buf_rd_i = 1'b1;
    cyc(1);
    buf_rd_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy_o; i++) cyc(1);
    cyc(2);
  endtask

  task automatic master_xfer(input logic [7:0] d, output logic [7:0] r);
    host_wr(d);
    wait_idle();
    r = buf_rdata_o;
  endtask

  task automatic measure(input logic [7:0] d, output int per);
    int t = 0, first = -1, second = -1;
    logic prev;
    host_wr(d);
    prev = sck_o;
    while (second < 0 && t < 3000) begin
      cyc(1); t++;
      if (prev == cpol_i && sck_o != cpol_i) begin
        if (first < 0) first = t; else second = t;
      end
      prev = sck_o;
    end
    per = second - first;
    wait_idle();
  endtask

  task automatic slave_xfer(input logic [7:0] mosi, output logic [7:0] miso, input int nbits);
    miso = '0;
    for (int i = 0; i < nbits; i++) begin
      sck_i = ~cpol_i; sdi_drv = mosi[7-i];
      cyc(HALF);
      miso[7-i] = sdo_o;
      sck_i = cpol_i;
      cyc(HALF);
    end
    cyc(6);
  endtask

  initial begin
    logic [7:0] d, r, a, b, seen, rd;
    int per;

    cyc(3);
    // R1 reset state
    chk(!wcol_o && !ovf_o && !buf_full_o && !busy_o, "R1 flags", {wcol_o, ovf_o, buf_full_o, busy_o}, 0);
    chk(buf_rdata_o == 8'h00, "R1 buffer", buf_rdata_o, 0);
    chk(!sck_oe_o && !sdo_oe_o, "R1 oe", {sck_oe_o, sdo_oe_o}, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R2 disabled: pins inert
    loop_en = 1'b0; mode_i = 4'b0101;
    slave_xfer(8'hA5, seen, 8);
    chk(!sck_oe_o && !sdo_oe_o, "R2 oe while disabled", {sck_oe_o, sdo_oe_o}, 0);
    chk(!buf_full_o && !busy_o, "R2 no byte while disabled", {buf_full_o, busy_o}, 0);

    // R3/R4/R5 master, directed
    loop_en = 1'b1; en_i = 1'b1;
    for (int m = 0; m < 4; m++) begin
      mode_i = 4'(m);
      cyc(2);
      chk(sck_o == cpol_i, "R5 idle level", sck_o, cpol_i);
      d = 8'h81 ^ 8'(m * 37);
      measure(d, per);
      chk(per == exp_period(mode_i), "R4 sck period", per, exp_period(mode_i));
      chk(buf_full_o && buf_rdata_o == d, "R3 loopback", buf_rdata_o, d);
      host_rd(rd);
      chk(!buf_full_o, "R12 read clears full", buf_full_o, 0);
    end

    // R3/R5 random master
    void'($urandom(32'h5eed));
    for (int k = 0; k < 20; k++) begin
      mode_i = 4'($urandom_range(0, 2));
      cpol_i = 1'($urandom_range(0, 1));
      cyc(2);
      chk(sck_o == cpol_i, "R5 idle level random", sck_o, cpol_i);
      d = 8'($urandom);
      master_xfer(d, r);
      chk(r == d, "R3 random loopback", r, d);
      host_rd(rd);
    end

    // R8 master: unread bytes never overflow
    mode_i = 4'b0000; cpol_i = 1'b0; cyc(2);
    master_xfer(8'h3C, r);
    master_xfer(8'hC3, r);
    chk(!ovf_o, "R8 no overflow", ovf_o, 0);
    chk(r == 8'hC3, "R8 newest byte kept", r, 8'hC3);
    host_rd(rd);

    // R6 write collision
    mode_i = 4'b0010; cyc(2);
    host_wr(8'h5A);
    cyc(5);
    host_wr(8'hFF);
    chk(wcol_o, "R6 collision set", wcol_o, 1);
    wait_idle();
    chk(buf_rdata_o == 8'h5A, "R6 byte in flight kept", buf_rdata_o, 8'h5A);
    cyc(10);
    chk(wcol_o, "R6 collision sticky", wcol_o, 1);
    clr_wcol_i = 1'b1; cyc(1); clr_wcol_i = 1'b0;
    chk(!wcol_o, "R6 collision cleared", wcol_o, 0);
    host_rd(rd);

    // R10/R11 slave without select, random
    loop_en = 1'b0; mode_i = 4'b0101; ss_ni = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cpol_i = 1'($urandom_range(0, 1));
      sck_i = cpol_i;
      cyc(6);
      chk(sdo_oe_o, "R10 drives without select", sdo_oe_o, 1);
      a = 8'($urandom); b = 8'($urandom);
      host_wr(b);
      slave_xfer(a, seen, 8);
      chk(seen == b, "R11 slave transmit", seen, b);
      chk(buf_full_o && buf_rdata_o == a, "R10 slave receive", buf_rdata_o, a);
      host_rd(rd);
    end

    // R7 overflow
    cpol_i = 1'b0; sck_i = 1'b0; cyc(6);
    slave_xfer(8'h11, seen, 8);
    slave_xfer(8'h22, seen, 8);
    chk(ovf_o, "R7 overflow set", ovf_o, 1);
    chk(buf_rdata_o == 8'h11, "R7 old byte kept", buf_rdata_o, 8'h11);
    cyc(10);
    chk(ovf_o, "R7 overflow sticky", ovf_o, 1);
    clr_ovf_i = 1'b1; cyc(1); clr_ovf_i = 1'b0;
    chk(!ovf_o, "R7 overflow cleared", ovf_o, 0);
    host_rd(rd);

    // R9 select honoured, mid-byte abort
    mode_i = 4'b0100; ss_ni = 1'b1; cyc(6);
    chk(!sdo_oe_o, "R9 sdo released when deselected", sdo_oe_o, 0);
    ss_ni = 1'b0; cyc(6);
    chk(sdo_oe_o, "R9 sdo driven when selected", sdo_oe_o, 1);
    slave_xfer(8'hF0, seen, 3);
    ss_ni = 1'b1; cyc(6);
    chk(!buf_full_o && !busy_o, "R9 partial byte dropped", {buf_full_o, busy_o}, 0);
    ss_ni = 1'b0; cyc(6);
    slave_xfer(8'h69, seen, 8);
    chk(buf_full_o && buf_rdata_o == 8'h69, "R9 realigned byte", buf_rdata_o, 8'h69);
    chk(!ovf_o, "R9 no overflow after abort", ovf_o, 0);
    host_rd(rd);
    ss_ni = 1'b1;

    // R2 disable drops busy
    en_i = 1'b0; cyc(2);
    chk(!busy_o && !sdo_oe_o && !sck_oe_o, "R2 disabled idle", {busy_o, sdo_oe_o, sck_oe_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule